// File: doc/BRIEF.md
# Operand Value Decoder

This block resolves the two 6-bit operand codes of one instruction for a 16-bit, word-addressed processor. The processor has eight general registers plus SP, PC and an overflow register. For each operand the block returns the value to read and the place a result would go. To do this it fetches immediate words from the instruction stream, reads data memory, and applies the stack pointer side effects of stack-style operands.

The control unit pulses `start` with both codes and the current SP, PC and overflow values. The general registers, SP, PC and the overflow register must stay stable until `done`. The block then talks to a synchronous memory: a read issued in one cycle returns its word on the next cycle. Operand a is resolved completely before operand b. When `done` pulses, the control unit commits `sp_out` and `pc_out`, uses the two values, and later writes its result to the reported target. Because PC is an ordinary target, a write to it acts as a jump. The `extra_cycles` count is added to the instruction's cycle cost. All address arithmetic wraps at 2^16.

Top module: `opdec_unit`

## Requirements
- R1: Codes 0x00–0x07 read general register n (n = code bits 2:0), report target kind 0 (register) with n in the address field, and make no memory access.
- R2: Codes 0x08–0x0f read the memory word at the address held in general register n, and report target kind 1 (memory) with that address.
- R3: Codes 0x10–0x17 and 0x1e read an immediate word at the working PC and then advance PC by one. The effective address is that word plus general register n (0x10–0x17), or the word alone (0x1e). The value is the memory word at that address, with target kind 1.
- R4: Code 0x18 (pop) addresses the word at SP and then increments SP.
- R5: Code 0x19 (peek) addresses the word at SP and leaves SP unchanged.
- R6: Code 0x1a (push) decrements SP and then addresses the word at the new SP. The value is that memory word.
- R7: Codes 0x1b, 0x1c and 0x1d read the working SP, the working PC and the overflow register. They report kinds 2, 3 and 4 respectively, so a write to PC is a jump.
- R8: Code 0x1f returns the immediate word at PC as its value, advances PC, and reports kind 5 (discarded write).
- R9: Codes 0x20–0x3f return the value code−0x20, report kind 5 (discarded write), and make no memory access.
- R10: Operand a is resolved before operand b. Operand b sees the SP and PC left by operand a. `sp_out` and `pc_out` carry the combined effect, wrapping modulo 2^16.
- R11: `extra_cycles` equals the number of immediate-word fetches (0 to 2) made for the instruction.
- R12: During and after reset, `done` and `mem_req` are low. No memory read is issued outside a decode.
- R13: `done` is a one-cycle pulse. A `start` while a decode is in progress is ignored. All results hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding one instruction's operands |
| code_a | input | 6 | Operand a value code |
| code_b | input | 6 | Operand b value code |
| gpr_flat | input | 128 | Eight general registers, register n at bits 16n+15:16n |
| sp_in | input | 16 | Stack pointer at start |
| pc_in | input | 16 | PC at start (word after the instruction word) |
| ovf_in | input | 16 | Overflow register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| done | output | 1 | Results valid pulse |
| a_value | output | 16 | Operand a read value |
| a_kind | output | 3 | Operand a target kind (0 reg, 1 mem, 2 SP, 3 PC, 4 overflow, 5 discard) |
| a_addr | output | 16 | Operand a register index or memory address |
| b_value | output | 16 | Operand b read value |
| b_kind | output | 3 | Operand b target kind |
| b_addr | output | 16 | Operand b register index or memory address |
| sp_out | output | 16 | SP after both operands |
| pc_out | output | 16 | PC after both operands |
| extra_cycles | output | 2 | Immediate-word fetches made |

## Verification
The checker module watches every cycle. It checks that `done` is a single-cycle pulse, that memory reads happen only inside a decode, that PC grows by exactly `extra_cycles`, that SP moves by at most two words, and that the number of reads is consistent with the fetch count. Only the bench scenarios can show that values, target kinds and addresses are correct. The bench sweeps all 4096 code pairs against a memory whose contents are computed, under register and pointer values chosen to make the address arithmetic wrap. The bench also covers reset, ignoring `start` while busy, and holding results after `done`.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  typedef enum logic [2:0] {
    TK_REG = 3'd0,
    TK_MEM = 3'd1,
    TK_SP  = 3'd2,
    TK_PC  = 3'd3,
    TK_OVF = 3'd4,
    TK_LIT = 3'd5
  } tgt_kind_t;

  typedef enum logic [1:0] {
    SK_NONE = 2'd0,
    SK_POP  = 2'd1,
    SK_PEEK = 2'd2,
    SK_PUSH = 2'd3
  } stk_t;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_EVAL = 3'd1,
    S_NWD  = 3'd2,
    S_MEM  = 3'd3,
    S_MEMD = 3'd4,
    S_DONE = 3'd5
  } seq_t;
endpackage

// File: rtl/op_classify.sv
module op_classify
  import opdec_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic [CW-1:0] code,
  output logic          needs_nw,
  output logic          needs_mem,
  output stk_t          stk,
  output tgt_kind_t     kind
);
  always_comb begin
    needs_nw  = 1'b0;
    needs_mem = 1'b0;
    stk       = SK_NONE;
    kind      = TK_LIT;
    if (!code[5]) begin
      unique case (code[4:3])
        2'b00: kind = TK_REG;
        2'b01: begin kind = TK_MEM; needs_mem = 1'b1; end
        2'b10: begin kind = TK_MEM; needs_mem = 1'b1; needs_nw = 1'b1; end
        default: begin
          unique case (code[2:0])
            3'd0: begin kind = TK_MEM; needs_mem = 1'b1; stk = SK_POP;  end
            3'd1: begin kind = TK_MEM; needs_mem = 1'b1; stk = SK_PEEK; end
            3'd2: begin kind = TK_MEM; needs_mem = 1'b1; stk = SK_PUSH; end
            3'd3: kind = TK_SP;
            3'd4: kind = TK_PC;
            3'd5: kind = TK_OVF;
            3'd6: begin kind = TK_MEM; needs_mem = 1'b1; needs_nw = 1'b1; end
            default: begin kind = TK_LIT; needs_nw = 1'b1; end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/op_resolve.sv
module op_resolve #(
  parameter int CW   = 6,
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [CW-1:0]      code,
  input  logic [DW*NREG-1:0] gpr_flat,
  input  logic [DW-1:0]      sp,
  input  logic [DW-1:0]      pc,
  input  logic [DW-1:0]      ovf,
  input  logic [DW-1:0]      nw,
  output logic [DW-1:0]      ea,
  output logic [DW-1:0]      dval
);
  logic [RW-1:0] ridx;
  logic [DW-1:0] rsel;

  assign ridx = code[RW-1:0];
  assign rsel = gpr_flat[ridx*DW +: DW];

  always_comb begin
    ea = '0;
    unique case (code[4:3])
      2'b01: ea = rsel;
      2'b10: ea = nw + rsel;
      2'b11: begin
        unique case (code[2:0])
          3'd0, 3'd1: ea = sp;
          3'd2:       ea = sp - 1'b1;
          3'd6:       ea = nw;
          default:    ea = '0;
        endcase
      end
      default: ea = '0;
    endcase
  end

  always_comb begin
    dval = '0;
    if (code[5]) begin
      dval = {{(DW-5){1'b0}}, code[4:0]};
    end else begin
      unique case (code[4:3])
        2'b00: dval = rsel;
        2'b11: begin
          unique case (code[2:0])
            3'd3:    dval = sp;
            3'd4:    dval = pc;
            3'd5:    dval = ovf;
            3'd7:    dval = nw;
            default: dval = '0;
          endcase
        end
        default: dval = '0;
      endcase
    end
  end
endmodule

// File: rtl/opdec_unit.sv
module opdec_unit
  import opdec_pkg::*;
#(
  parameter int CW   = 6,
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int GW  = DW * NREG,
  localparam int RW  = $clog2(NREG),
  localparam int XW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] code_a,
  input  logic [CW-1:0] code_b,
  input  logic [GW-1:0] gpr_flat,
  input  logic [DW-1:0] sp_in,
  input  logic [DW-1:0] pc_in,
  input  logic [DW-1:0] ovf_in,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] a_value,
  output logic [2:0]    a_kind,
  output logic [DW-1:0] a_addr,
  output logic [DW-1:0] b_value,
  output logic [2:0]    b_kind,
  output logic [DW-1:0] b_addr,
  output logic [DW-1:0] sp_out,
  output logic [DW-1:0] pc_out,
  output logic [XW-1:0] extra_cycles
);
  seq_t          st_q, st_d;
  logic          cur_q, cur_d;
  logic [CW-1:0] ca_q, ca_d, cb_q, cb_d;
  logic [DW-1:0] sp_q, sp_d, pc_q, pc_d, ovf_q, ovf_d, nw_q, nw_d;
  logic [XW-1:0] ext_q, ext_d;
  logic [DW-1:0] av_q, av_d, aa_q, aa_d, bv_q, bv_d, ba_q, ba_d;
  logic [2:0]    ak_q, ak_d, bk_q, bk_d;

  logic [CW-1:0] cur_code;
  logic [DW-1:0] nw_cur, ea, dval, fin_val, fin_addr;
  logic          needs_nw, needs_mem, fin;
  stk_t          stk;
  tgt_kind_t     kind;

  assign cur_code = cur_q ? cb_q : ca_q;
  assign nw_cur   = (st_q == S_NWD) ? mem_rdata : nw_q;

  op_classify #(.CW(CW)) u_cls (
    .code(cur_code), .needs_nw(needs_nw), .needs_mem(needs_mem),
    .stk(stk), .kind(kind)
  );

  op_resolve #(.CW(CW), .DW(DW), .NREG(NREG)) u_res (
    .code(cur_code), .gpr_flat(gpr_flat), .sp(sp_q), .pc(pc_q),
    .ovf(ovf_q), .nw(nw_cur), .ea(ea), .dval(dval)
  );

  always_comb begin
    st_d = st_q; cur_d = cur_q; ca_d = ca_q; cb_d = cb_q;
    sp_d = sp_q; pc_d = pc_q; ovf_d = ovf_q; nw_d = nw_q; ext_d = ext_q;
    av_d = av_q; aa_d = aa_q; ak_d = ak_q;
    bv_d = bv_q; ba_d = ba_q; bk_d = bk_q;
    mem_req = 1'b0; mem_addr = '0; fin = 1'b0; fin_val = dval;
    unique case (st_q)
      S_IDLE: if (start) begin
        ca_d = code_a; cb_d = code_b;
        sp_d = sp_in; pc_d = pc_in; ovf_d = ovf_in;
        cur_d = 1'b0; ext_d = '0; st_d = S_EVAL;
      end
      S_EVAL: begin
        if (needs_nw) begin
          mem_req = 1'b1; mem_addr = pc_q; st_d = S_NWD;
        end else if (needs_mem) begin
          mem_req = 1'b1; mem_addr = ea; st_d = S_MEMD;
        end else begin
          fin = 1'b1;
        end
      end
      S_NWD: begin
        nw_d  = mem_rdata;
        pc_d  = pc_q + 1'b1;
        ext_d = ext_q + 1'b1;
        if (needs_mem) st_d = S_MEM;
        else           fin  = 1'b1;
      end
      S_MEM: begin
        mem_req = 1'b1; mem_addr = ea; st_d = S_MEMD;
      end
      S_MEMD: begin
        fin = 1'b1; fin_val = mem_rdata;
        if (stk == SK_POP)  sp_d = sp_q + 1'b1;
        if (stk == SK_PUSH) sp_d = sp_q - 1'b1;
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (fin) begin
      if (!cur_q) begin
        av_d = fin_val; ak_d = kind; aa_d = fin_addr;
        cur_d = 1'b1; st_d = S_EVAL;
      end else begin
        bv_d = fin_val; bk_d = kind; ba_d = fin_addr;
        st_d = S_DONE;
      end
    end
  end

  always_comb begin
    unique case (kind)
      TK_REG:  fin_addr = {{(DW-RW){1'b0}}, cur_code[RW-1:0]};
      TK_MEM:  fin_addr = ea;
      default: fin_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= 1'b0; ca_q <= '0; cb_q <= '0;
      sp_q <= '0; pc_q <= '0; ovf_q <= '0; nw_q <= '0; ext_q <= '0;
      av_q <= '0; aa_q <= '0; ak_q <= '0;
      bv_q <= '0; ba_q <= '0; bk_q <= '0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; ca_q <= ca_d; cb_q <= cb_d;
      sp_q <= sp_d; pc_q <= pc_d; ovf_q <= ovf_d; nw_q <= nw_d; ext_q <= ext_d;
      av_q <= av_d; aa_q <= aa_d; ak_q <= ak_d;
      bv_q <= bv_d; ba_q <= ba_d; bk_q <= bk_d;
    end
  end

  assign done         = (st_q == S_DONE);
  assign a_value      = av_q;
  assign a_kind       = ak_q;
  assign a_addr       = aa_q;
  assign b_value      = bv_q;
  assign b_kind       = bk_q;
  assign b_addr       = ba_q;
  assign sp_out       = sp_q;
  assign pc_out       = pc_q;
  assign extra_cycles = ext_q;
endmodule

// File: rtl/opdec_unit_chk.sv
module opdec_unit_chk #(
  parameter int DW = 16,
  parameter int XW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_req,
  input logic          done,
  input logic [DW-1:0] sp_in,
  input logic [DW-1:0] pc_in,
  input logic [DW-1:0] sp_out,
  input logic [DW-1:0] pc_out,
  input logic [XW-1:0] extra_cycles
);
  logic          busy_q;
  logic [DW-1:0] sp_cap, pc_cap, sp_dif;
  logic [2:0]    req_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sp_cap <= '0; pc_cap <= '0; req_cnt <= '0;
    end else begin
      if (start && !busy_q) begin
        busy_q <= 1'b1; sp_cap <= sp_in; pc_cap <= pc_in; req_cnt <= '0;
      end else begin
        if (done) busy_q <= 1'b0;
        if (mem_req && req_cnt != 3'd7) req_cnt <= req_cnt + 1'b1;
      end
    end
  end

  assign sp_dif = sp_out - sp_cap;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R13
  AST_REQ_IN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (busy_q && !done)); // R12
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pc_out == pc_cap + {{(DW-XW){1'b0}}, extra_cycles})); // R11
  AST_SP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sp_dif == '0 || sp_dif == 1 || sp_dif == 2 ||
              sp_dif == {DW{1'b1}} || sp_dif == {{(DW-1){1'b1}}, 1'b0})); // R10
  AST_REQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_cnt >= {1'b0, extra_cycles} && req_cnt <= 3'd4)); // R11
endmodule

bind opdec_unit opdec_unit_chk #(.DW(DW), .XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .done(done),
  .sp_in(sp_in), .pc_in(pc_in), .sp_out(sp_out), .pc_out(pc_out),
  .extra_cycles(extra_cycles)
);

// File: tb/opdec_unit_test.sv
module opdec_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  code_a = '0, code_b = '0;
  logic [15:0] gpr [8];
  logic [127:0] gpr_flat;
  logic [15:0] sp_in = '0, pc_in = '0, ovf_in = '0;
  logic        mem_req, done;
  logic [15:0] mem_addr, mem_rdata = '0;
  logic [15:0] a_value, a_addr, b_value, b_addr, sp_out, pc_out;
  logic [2:0]  a_kind, b_kind;
  logic [1:0]  extra_cycles;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) gpr_flat[i*16 +: 16] = gpr[i];

  opdec_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .code_a(code_a), .code_b(code_b),
    .gpr_flat(gpr_flat), .sp_in(sp_in), .pc_in(pc_in), .ovf_in(ovf_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
    .a_value(a_value), .a_kind(a_kind), .a_addr(a_addr),
    .b_value(b_value), .b_kind(b_kind), .b_addr(b_addr),
    .sp_out(sp_out), .pc_out(pc_out), .extra_cycles(extra_cycles)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a * 16'd41) ^ 16'hA5C3;
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

  function automatic string rq(input logic [5:0] c);
    if (c >= 6'h20) return "R9";
    if (c < 6'h08)  return "R1";
    if (c < 6'h10)  return "R2";
    if (c < 6'h18)  return "R3";
    case (c)
      6'h18: return "R4";
      6'h19: return "R5";
      6'h1a: return "R6";
      6'h1e: return "R3";
      6'h1f: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic ref_op(input logic [5:0] c, inout logic [15:0] sp, inout logic [15:0] pc,
                        inout int ext, output logic [15:0] v, output logic [2:0] k,
                        output logic [15:0] ad);
    logic [15:0] r, nw;
    r = gpr[c[2:0]]; ad = '0;
    if (c >= 6'h20) begin v = {11'd0, c[4:0]}; k = 3'd5; end
    else if (c < 6'h08) begin v = r; k = 3'd0; ad = {13'd0, c[2:0]}; end
    else if (c < 6'h10) begin ad = r; v = memf(ad); k = 3'd1; end
    else if (c < 6'h18) begin
      nw = memf(pc); pc = pc + 16'd1; ext++; ad = nw + r; v = memf(ad); k = 3'd1;
    end else begin
      case (c)
        6'h18: begin ad = sp; v = memf(ad); sp = sp + 16'd1; k = 3'd1; end
        6'h19: begin ad = sp; v = memf(ad); k = 3'd1; end
        6'h1a: begin sp = sp - 16'd1; ad = sp; v = memf(ad); k = 3'd1; end
        6'h1b: begin v = sp; k = 3'd2; end
        6'h1c: begin v = pc; k = 3'd3; end
        6'h1d: begin v = ovf_in; k = 3'd4; end
        6'h1e: begin nw = memf(pc); pc = pc + 16'd1; ext++; ad = nw; v = memf(ad); k = 3'd1; end
        default: begin nw = memf(pc); pc = pc + 16'd1; ext++; v = nw; k = 3'd5; end
      endcase
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin n_chk++; n_err++; $display("FAIL R13 done timeout: actual=0 expected=1"); end
  endtask

  task automatic run_pair(input logic [5:0] ca, input logic [5:0] cb);
    logic [15:0] sp, pc, va, vb, ada, adb;
    logic [2:0]  ka, kb;
    int ext;
    bit ok;
    sp = sp_in; pc = pc_in; ext = 0;
    ref_op(ca, sp, pc, ext, va, ka, ada);
    ref_op(cb, sp, pc, ext, vb, kb, adb);
    @(negedge clk); code_a = ca; code_b = cb; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (done) begin ok = 1; end else wait_done(ok);
    if (!ok) return;
    chk(rq(ca), "a_value", a_value, va);
    chk(rq(ca), "a_kind", {13'd0, a_kind}, {13'd0, ka});
    chk(rq(ca), "a_addr", a_addr, ada);
    chk(rq(cb), "b_value", b_value, vb);
    chk(rq(cb), "b_kind", {13'd0, b_kind}, {13'd0, kb});
    chk(rq(cb), "b_addr", b_addr, adb);
    chk("R10", "sp_out", sp_out, sp);
    chk("R10", "pc_out", pc_out, pc);
    chk("R11", "extra_cycles", {14'd0, extra_cycles}, ext[15:0]);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) gpr[i] = 16'(i * 16'h1111 + 3);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++; n_err++;
      $display("FAIL R13 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] hold_v;
    bit ok;
    repeat (3) @(negedge clk);
    chk("R12", "done in reset", {15'd0, done}, 16'd0);
    chk("R12", "mem_req in reset", {15'd0, mem_req}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "done after reset", {15'd0, done}, 16'd0);
    chk("R12", "mem_req idle", {15'd0, mem_req}, 16'd0);

    // R13: second start while busy is ignored; results hold after done
    sp_in = 16'h0100; pc_in = 16'h0200; ovf_in = 16'h00AA;
    @(negedge clk); code_a = 6'h1f; code_b = 6'h10; start = 1'b1;
    @(negedge clk); code_a = 6'h21; code_b = 6'h22;
    @(negedge clk); start = 1'b0;
    wait_done(ok);
    chk("R13", "busy start ignored a_value", a_value, memf(16'h0200));
    chk("R13", "busy start ignored pc_out", pc_out, 16'h0202);
    hold_v = b_value;
    repeat (4) @(negedge clk);
    chk("R13", "done pulse low", {15'd0, done}, 16'd0);
    chk("R13", "b_value held", b_value, hold_v);
    chk("R12", "no request after done", {15'd0, mem_req}, 16'd0);

    // Exhaustive sweep of all code pairs with wrapping pointers
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        int idx;
        idx = a * 64 + b;
        case (idx % 4)
          0: sp_in = 16'h0000;
          1: sp_in = 16'hFFFF;
          2: sp_in = 16'h1234;
          default: sp_in = 16'h8000;
        endcase
        case ((idx / 4) % 4)
          0: pc_in = 16'hFFFF;
          1: pc_in = 16'h0100;
          2: pc_in = 16'hFFFE;
          default: pc_in = 16'h4000;
        endcase
        ovf_in = 16'(idx ^ 16'h5A5A);
        for (int i = 0; i < 8; i++) gpr[i] = 16'((idx * 7 + i * 16'h2345) ^ 16'hF00F);
        run_pair(6'(a), 6'(b));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule